// File: doc/BRIEF.md
# DMA Bus Handover Cycle Sequencer

This block is the bus-master timing engine of a four-channel DMA controller. A pending request on any enabled channel makes it ask the host for the system bus. Once the host grants the bus, the block runs fixed-length transfer cycles for the channel chosen by an external priority block. It drives the active-low acknowledge for that channel, the address-enable and upper-address latch strobe, the low address byte, and the memory and I/O read/write strobes that match the transfer type. A verify cycle keeps the full timing but asserts no strobe.

Each cycle passes through an address state, a read-strobe state, a write-strobe state, optional wait states while the peripheral holds ready low, and an end state. The block keeps the bus and starts the next cycle straight away while a request remains and the grant is still high. Otherwise it returns the bus to the host. Register contents (address, count, type, enables) and the priority decision come from neighbouring blocks.

Top module: `dma_cycle_seq`

## Requirements
- R1: The hold request `hrq` is high whenever some channel has both `chReq` and `chEnable` high, and also whenever the block owns the bus. When idle, requests on disabled channels do not raise it.
- R2: A transfer cycle (ownership, shown by `aen` rising) starts only on a clock edge at which `hlda` is high and an enabled request is pending.
- R3: While the bus is owned, exactly one bit of `dackN` is low: the bit of the channel that `winChan` named when the cycle started. When not owning, all bits of `dackN` are high.
- R4: `aen` is high from the first state of a cycle through its end state, and across back-to-back cycles.
- R5: In the first clock of every cycle, `adstb` is high for exactly one clock, `dataOe` is high, and `dataOut` carries bits 15:8 of the address captured at cycle start. `dataOe` is low at all other times.
- R6: While owning, `addrOe` is high and `addrOut` carries bits 7:0 of the captured address, with bits 3:0 on the low nibble and bits 7:4 on the high nibble.
- R7: A cycle runs address state, read state and write state for one clock each, then any wait states, then one end state.
- R8: Transfer type is `{bit15,bit14}` of the count word. Type 2'b01 (write to memory) asserts `ioRdN` in the read, write and wait states and `memWrN` in the write and wait states. Type 2'b10 (read from memory) asserts `memRdN` and `ioWrN` with the same timing.
- R9: If `ready` is low in the write state or in a wait state, the next clock is another wait state with the same strobes held. The end state follows the first such clock with `ready` high.
- R10: With `extWrite` high, the write strobe of the cycle is also asserted during the read state, one clock earlier than normal.
- R11: Types 2'b00 and 2'b11 (verify) run the full timing with all four strobes high (inactive).
- R12: In the end state, if `hlda` is high and an enabled request is pending, the next clock starts a new cycle. Otherwise the block goes idle, and `hrq` falls unless a request is pending.
- R13: `regSel` follows the active-low `csN` when idle and stays low while the bus is owned, whatever `csN` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chReq | input | 4 | Per-channel transfer requests |
| chEnable | input | 4 | Per-channel enables from the mode register |
| winChan | input | 2 | Channel picked by the priority block |
| memAddr | input | 16 | Current address of the picked channel |
| xferType | input | 2 | Transfer type of the picked channel |
| extWrite | input | 1 | Early write strobe mode |
| hlda | input | 1 | Bus grant from the host |
| ready | input | 1 | Peripheral ready; low inserts wait states |
| csN | input | 1 | Active-low register chip select |
| hrq | output | 1 | Bus hold request |
| dackN | output | 4 | Active-low per-channel acknowledges |
| aen | output | 1 | Address enable, high while owning the bus |
| adstb | output | 1 | Upper address latch strobe |
| dataOut | output | 8 | Upper address byte for the data lines |
| dataOe | output | 1 | Drive enable for dataOut |
| addrOut | output | 8 | Low address byte |
| addrOe | output | 1 | Drive enable for addrOut |
| memRdN | output | 1 | Active-low memory read strobe |
| memWrN | output | 1 | Active-low memory write strobe |
| ioRdN | output | 1 | Active-low I/O read strobe |
| ioWrN | output | 1 | Active-low I/O write strobe |
| regSel | output | 1 | Register access allowed (slave mode only) |

## Verification
A wrong sequencer state shows in the same clock as a misplaced `adstb` pulse, a strobe asserted one state early or late, or `aen` held or dropped wrongly. A stuck wait state shows as strobes that stay low after `ready` returns. A wrong captured channel, address or type shows at once on `dackN`, `dataOut`, `addrOut` or the strobe pair of the first affected cycle. Because every output is compared against a cycle-level model on every clock, any such divergence is reported in the first clock in which it becomes visible.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RDST,
    ST_WRST,
    ST_WAIT,
    ST_END
  } seqState_t;

  typedef struct packed {
    logic load;
    logic own;
    logic addrPhase;
    logic rdPhase;
    logic wrPhase;
  } seqCtrl_t;

  localparam logic [1:0] XFER_WRITE = 2'b01;
  localparam logic [1:0] XFER_READ  = 2'b10;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     anyReq,
  input  logic     hlda,
  input  logic     ready,
  input  logic     extWrite,
  output seqCtrl_t ctrl
);

  seqState_t state, stateNext;
  logic      startCycle;

  // A new cycle begins from idle or from the end state when granted
  assign startCycle = hlda && anyReq &&
                      (state == ST_IDLE || state == ST_END);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startCycle) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_RDST;
      ST_RDST: stateNext = ST_WRST;
      ST_WRST: stateNext = ready ? ST_END : ST_WAIT;
      ST_WAIT: stateNext = ready ? ST_END : ST_WAIT;
      ST_END:  stateNext = startCycle ? ST_ADDR : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    ctrl.load      = startCycle;
    ctrl.own       = (state != ST_IDLE);
    ctrl.addrPhase = (state == ST_ADDR);
    ctrl.rdPhase   = (state == ST_RDST) || (state == ST_WRST) ||
                     (state == ST_WAIT);
    ctrl.wrPhase   = (state == ST_WRST) || (state == ST_WAIT) ||
                     ((state == ST_RDST) && extWrite);
  end

endmodule

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCtrl_t          ctrl,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [CH_W-1:0]   winChan,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [1:0]        xferType,
  output logic              anyReq,
  output logic [NUM_CH-1:0] dackN,
  output logic [HI_W-1:0]   dataOut,
  output logic              dataOe,
  output logic [LO_W-1:0]   addrOut,
  output logic              addrOe,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN
);

  logic [CH_W-1:0]   chanQ;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        typeQ;

  assign anyReq = |(chReq & chEnable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chanQ <= '0;
      addrQ <= '0;
      typeQ <= '0;
    end else if (ctrl.load) begin
      chanQ <= winChan;
      addrQ <= memAddr;
      typeQ <= xferType;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dack
    assign dackN[ch] = !(ctrl.own && (chanQ == CH_W'(ch)));
  end

  assign dataOe  = ctrl.addrPhase;
  assign dataOut = ctrl.addrPhase ? addrQ[ADDR_W-1:LO_W] : '0;
  assign addrOe  = ctrl.own;
  assign addrOut = ctrl.own ? addrQ[LO_W-1:0] : '0;

  // Type selects which strobe pair the read and write phases drive
  assign ioRdN  = !(ctrl.rdPhase && typeQ == XFER_WRITE);
  assign memWrN = !(ctrl.wrPhase && typeQ == XFER_WRITE);
  assign memRdN = !(ctrl.rdPhase && typeQ == XFER_READ);
  assign ioWrN  = !(ctrl.wrPhase && typeQ == XFER_READ);

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  parameter int LO_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chReq,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [CH_W-1:0]   winChan,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [1:0]        xferType,
  input  logic              extWrite,
  input  logic              hlda,
  input  logic              ready,
  input  logic              csN,
  output logic              hrq,
  output logic [NUM_CH-1:0] dackN,
  output logic              aen,
  output logic              adstb,
  output logic [HI_W-1:0]   dataOut,
  output logic              dataOe,
  output logic [LO_W-1:0]   addrOut,
  output logic              addrOe,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              regSel
);

  seqCtrl_t ctrl;
  logic     anyReq;

  dma_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .anyReq   (anyReq),
    .hlda     (hlda),
    .ready    (ready),
    .extWrite (extWrite),
    .ctrl     (ctrl)
  );

  dma_seq_dpath #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .LO_W   (LO_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .chReq    (chReq),
    .chEnable (chEnable),
    .winChan  (winChan),
    .memAddr  (memAddr),
    .xferType (xferType),
    .anyReq   (anyReq),
    .dackN    (dackN),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .addrOut  (addrOut),
    .addrOe   (addrOe),
    .memRdN   (memRdN),
    .memWrN   (memWrN),
    .ioRdN    (ioRdN),
    .ioWrN    (ioWrN)
  );

  assign hrq    = anyReq || ctrl.own;
  assign aen    = ctrl.own;
  assign adstb  = ctrl.addrPhase;
  assign regSel = !csN && !ctrl.own;

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hlda,
  input logic              ready,
  input logic              hrq,
  input logic [NUM_CH-1:0] dackN,
  input logic              aen,
  input logic              adstb,
  input logic              dataOe,
  input logic              memRdN,
  input logic              memWrN,
  input logic              ioRdN,
  input logic              ioWrN,
  input logic              regSel
);

  a_r1_hold_while_owning: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> hrq);

  a_r2_grant_before_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> $past(hlda));

  a_r3_single_dack: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> ($countones(~dackN) == 1));

  a_r3_no_dack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !aen |-> (&dackN));

  a_r5_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> !adstb);

  a_r5_data_drive_first_clock: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> (adstb && aen));

  a_r8_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    !((!memRdN && !memWrN) || (!ioRdN && !ioWrN)));

  a_r9_write_held_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && (!memWrN || !ioWrN)) |=> (!memWrN || !ioWrN));

  a_r13_no_select_as_master: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !regSel);

endmodule

bind dma_cycle_seq dma_cycle_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hlda   (hlda),
  .ready  (ready),
  .hrq    (hrq),
  .dackN  (dackN),
  .aen    (aen),
  .adstb  (adstb),
  .dataOe (dataOe),
  .memRdN (memRdN),
  .memWrN (memWrN),
  .ioRdN  (ioRdN),
  .ioWrN  (ioWrN),
  .regSel (regSel)
);

// File: tb/dma_cycle_seq_bench.sv
module dma_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  chReq = '0, chEnable = '0;
  logic [1:0]  winChan = '0, xferType = '0;
  logic [15:0] memAddr = '0;
  logic        extWrite = 1'b0, hlda = 1'b0, ready = 1'b1, csN = 1'b1;
  logic        hrq, aen, adstb, dataOe, addrOe, regSel;
  logic        memRdN, memWrN, ioRdN, ioWrN;
  logic [3:0]  dackN;
  logic [7:0]  dataOut, addrOut;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model: 0 idle,1 addr,2 rd,3 wr,4 wait,5 end
  int          mState = 0;
  logic [1:0]  mChan = '0, mType = '0;
  logic [15:0] mAddr = '0;

  // stimulus knobs
  int  hldaPct = 85, readyPct = 75, enPct = 80;
  bit  fixType = 0;
  logic [1:0] typeVal = '0;

  always #5 clk = ~clk;

  dma_cycle_seq u_dma_cycle_seq (
    .clk(clk), .rst_n(rst_n), .chReq(chReq), .chEnable(chEnable),
    .winChan(winChan), .memAddr(memAddr), .xferType(xferType),
    .extWrite(extWrite), .hlda(hlda), .ready(ready), .csN(csN),
    .hrq(hrq), .dackN(dackN), .aen(aen), .adstb(adstb),
    .dataOut(dataOut), .dataOe(dataOe), .addrOut(addrOut), .addrOe(addrOe),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .regSel(regSel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom % 100) < p;
  endfunction

  function automatic logic [3:0] expDack(input int st, input logic [1:0] ch);
    return (st != 0) ? ~(4'b0001 << ch) : 4'b1111;
  endfunction

  // compare all outputs with the model, then advance the model one clock
  task automatic compareAndAdvance();
    bit own, rdOn, wrOn, anyR, isVer;
    string sTag;
    own  = (mState != 0);
    anyR = |(chReq & chEnable);
    rdOn = (mState == 2) || (mState == 3) || (mState == 4);
    wrOn = (mState == 3) || (mState == 4) || (mState == 2 && extWrite);
    isVer = (mType == 2'b00) || (mType == 2'b11);
    chk(hrq == (anyR || own), "R1 hold request", hrq, anyR || own);
    chk(aen == own, "R2 R4 R12 address enable", aen, own);
    chk(dackN == expDack(mState, mChan), "R3 acknowledge", dackN, expDack(mState, mChan));
    chk(adstb == (mState == 1) && dataOe == (mState == 1), "R5 strobe/drive",
        {adstb, dataOe}, {2{mState == 1}});
    if (mState == 1) chk(dataOut == mAddr[15:8], "R5 upper byte", dataOut, mAddr[15:8]);
    chk(addrOe == own, "R6 addr drive", addrOe, own);
    if (own) chk(addrOut == mAddr[7:0], "R6 low byte", addrOut, mAddr[7:0]);
    if (isVer)                       sTag = "R11 verify strobes";
    else if (mState == 4)            sTag = "R9 wait strobes";
    else if (mState == 2 && extWrite) sTag = "R10 early write";
    else                             sTag = "R7/R8 strobes";
    begin
      logic [3:0] expS;
      expS = {!(rdOn && mType == 2'b10), !(wrOn && mType == 2'b01),
              !(rdOn && mType == 2'b01), !(wrOn && mType == 2'b10)};
      chk({memRdN, memWrN, ioRdN, ioWrN} == expS, sTag,
          {memRdN, memWrN, ioRdN, ioWrN}, expS);
    end
    chk(regSel == (!csN && !own), "R13 chip select", regSel, !csN && !own);
    // model next state
    case (mState)
      0, 5: begin
        if (hlda && anyR) begin
          mState = 1; mChan = winChan; mAddr = memAddr; mType = xferType;
        end else mState = 0;
      end
      1: mState = 2;
      2: mState = 3;
      3, 4: mState = ready ? 5 : 4;
      default: mState = 0;
    endcase
  endtask

  task automatic randomStep();
    @(negedge clk);
    chReq    = 4'($urandom);
    chEnable = pct(enPct) ? 4'($urandom) | 4'b0001 : 4'($urandom);
    winChan  = 2'($urandom);
    memAddr  = 16'($urandom);
    xferType = fixType ? typeVal : 2'($urandom);
    hlda     = pct(hldaPct);
    ready    = pct(readyPct);
    csN      = pct(50);
    #1;
    compareAndAdvance();
  endtask

  initial begin
    void'($urandom(32'd20240517));
    // reset state after an edge with reset held
    @(negedge clk); #1;
    chk(hrq == 0 && aen == 0 && dackN == 4'hF && adstb == 0, "R1 R3 reset idle",
        {hrq, aen, dackN, adstb}, {1'b0, 1'b0, 4'hF, 1'b0});
    chk({memRdN, memWrN, ioRdN, ioWrN} == 4'hF, "R8 reset strobes",
        {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    @(negedge clk); rst_n = 1'b1;

    // directed: requests on disabled channels only, no hold request
    @(negedge clk); chReq = 4'b1010; chEnable = 4'b0101; hlda = 1'b1; #1;
    compareAndAdvance();
    chk(hrq == 0, "R1 disabled request ignored", hrq, 0);
    // directed: request without grant never starts a cycle
    chEnable = 4'b0010; hlda = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1; compareAndAdvance();
    end
    chk(aen == 0 && hrq == 1, "R2 wait for grant", {hrq, aen}, 2'b10);

    // directed long wait: ready held low
    readyPct = 10; hldaPct = 100;
    for (int i = 0; i < 60; i++) randomStep();
    // verify-only traffic
    fixType = 1; typeVal = 2'b00; readyPct = 70;
    for (int i = 0; i < 60; i++) randomStep();
    // early write mode on write and read types
    extWrite = 1; fixType = 1;
    typeVal = 2'b01; for (int i = 0; i < 80; i++) randomStep();
    typeVal = 2'b10; for (int i = 0; i < 80; i++) randomStep();
    extWrite = 0; fixType = 0;
    // sparse requests to exercise bus release
    enPct = 20; hldaPct = 60;
    for (int i = 0; i < 400; i++) randomStep();
    // general random mix
    enPct = 80; hldaPct = 85; readyPct = 75;
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 250) extWrite = ~extWrite;
      randomStep();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule